// File: doc/BRIEF.md
# Dual Watermark FIFO for a Serial Port

This block buffers traffic between a processor or DMA bus and a serial shifter. It holds one 16-entry FIFO in each direction. The bus writes into the transmit FIFO and the shifter drains it. The shifter fills the receive FIFO and the bus reads it out.

Each direction has its own request output, driven by a 3-bit watermark select. The transmit side measures free entries and the receive side measures stored entries, and the two directions map the same select codes to thresholds in opposite order. A request is raised only while its threshold is met and is dropped as soon as it is not, even if the FIFO is partly filled.

Accesses that would overfill or overdrain a FIFO are refused and recorded in sticky error flags. Software clears these flags by writing one to them.

Top module: `sio_fifo_pair`

## Requirements
- R1: While `rstN` is low both FIFOs are empty. `txFreeCnt` is 16, `rxFillCnt` is 0, `errFlags` is 0, both requests are 0 and both data outputs are 0.
- R2: `txFreeCnt` reports the number of empty transmit entries (0..16). A `busWrEn` stores `busWrData`, and a `serTxPop` removes the oldest entry, so data leaves in write order.
- R3: `rxFillCnt` reports the number of valid receive entries (0..16). A `serRxPush` stores `serRxData`, and a `busRdEn` removes the oldest entry, so data leaves in arrival order.
- R4: `txReq` is 1 when the free count is at least the threshold selected by `txMarkSel`. The thresholds are: 3'b000 → 16, 3'b100 → 12, 3'b101 → 8, 3'b110 → 4, 3'b111 → 1.
- R5: `rxReq` is 1 when the fill count is at least the threshold selected by `rxMarkSel`. The thresholds are: 3'b000 → 1, 3'b100 → 4, 3'b101 → 8, 3'b110 → 12, 3'b111 → 16.
- R6: Select codes 3'b001, 3'b010 and 3'b011 act exactly like 3'b000 in both directions.
- R7: Requests are registered. After each clock edge, a request equals its R4/R5 condition evaluated on the count after that edge and on the select sampled at that edge. A request drops in the same cycle its condition fails, whatever the fill level.
- R8: A write to a full FIFO is discarded, the count stays unchanged, and an overflow flag is set. The transmit overflow flag is `errFlags[0]` and the receive overflow flag is `errFlags[2]`.
- R9: A read from an empty FIFO leaves the count unchanged and holds the previous data output. It sets an underflow flag: `errFlags[1]` for transmit and `errFlags[3]` for receive.
- R10: Error flags are sticky. Writing 1 to bit i of `errClr` clears `errFlags[i]`. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: When a push and a pop are both accepted in the same cycle on one FIFO, that FIFO's count does not change.
- R12: `serTxData` and `busRdData` are registered. Each updates at the edge that accepts its pop and holds at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Bus write into the transmit FIFO |
| busWrData | input | 8 | Bus write data |
| busRdEn | input | 1 | Bus read from the receive FIFO |
| busRdData | output | 8 | Registered receive read data |
| txMarkSel | input | 3 | Transmit watermark select |
| rxMarkSel | input | 3 | Receive watermark select |
| errClr | input | 4 | Write-one-to-clear for the error flags |
| txReq | output | 1 | Transmit transfer request |
| rxReq | output | 1 | Receive transfer request |
| txFreeCnt | output | 5 | Empty transmit entries |
| rxFillCnt | output | 5 | Valid receive entries |
| errFlags | output | 4 | {rxUnder, rxOver, txUnder, txOver} |
| serTxPop | input | 1 | Shifter takes one transmit entry |
| serTxData | output | 8 | Registered transmit data toward the shifter |
| serRxPush | input | 1 | Shifter delivers one receive entry |
| serRxData | input | 8 | Receive data from the shifter |

## Verification
The bus side and the serial side can act on the same FIFO in the same cycle. That lets a push and a pop coincide, and at the full or empty boundary it lets an accepted access coincide with a refused one. The bench provokes this with random phases whose push and pop probabilities drive each FIFO to both limits while the other side stays active. A directed run fills and drains each FIFO past its limits. Every cycle, counts, requests, flags and data are compared with a queue model that applies the pop before the push and decides full and empty from the state before the edge.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStb_t;

  // receive side: valid entries needed before a request
  function automatic int unsigned rxNeed(input logic [2:0] sel, input int unsigned depth);
    case (sel)
      3'b100:  return depth / 4;
      3'b101:  return depth / 2;
      3'b110:  return (3 * depth) / 4;
      3'b111:  return depth;
      default: return 1;
    endcase
  endfunction

  // transmit side: empty entries needed before a request
  function automatic int unsigned txNeed(input logic [2:0] sel, input int unsigned depth);
    case (sel)
      3'b100:  return (3 * depth) / 4;
      3'b101:  return depth / 2;
      3'b110:  return depth / 4;
      3'b111:  return 1;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/sfp_fifo_dp.sv
module sfp_fifo_dp
  import sfp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStb_t      stb,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] fillNext
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop) begin
        rdPtr  <= bump(rdPtr);
        rdData <= mem[rdPtr];
      end
    end
  end

  always_comb begin
    case ({stb.push, stb.pop})
      2'b10:   fillNext = fill + CW'(1);
      2'b01:   fillNext = fill - CW'(1);
      default: fillNext = fill;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fill <= '0;
    else       fill <= fillNext;
  end

endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic          serTxPop,
  input  logic          serRxPush,
  input  logic [2:0]    txMarkSel,
  input  logic [2:0]    rxMarkSel,
  input  logic [3:0]    errClr,
  input  logic [CW-1:0] txFill,
  input  logic [CW-1:0] txFillNext,
  input  logic [CW-1:0] rxFill,
  input  logic [CW-1:0] rxFillNext,
  output fifoStb_t      txStb,
  output fifoStb_t      rxStb,
  output logic          txReq,
  output logic          rxReq,
  output logic [3:0]    errFlags
);

  logic          txFull, txEmpty, rxFull, rxEmpty;
  logic [3:0]    errSet;
  logic [CW-1:0] txFreeNext;
  logic          txReqNext, rxReqNext;

  assign txFull  = (txFill == CW'(DEPTH));
  assign txEmpty = (txFill == '0);
  assign rxFull  = (rxFill == CW'(DEPTH));
  assign rxEmpty = (rxFill == '0);

  always_comb begin
    txStb.push = busWrEn   && !txFull;
    txStb.pop  = serTxPop  && !txEmpty;
    rxStb.push = serRxPush && !rxFull;
    rxStb.pop  = busRdEn   && !rxEmpty;
  end

  assign errSet = {busRdEn && rxEmpty, serRxPush && rxFull,
                   serTxPop && txEmpty, busWrEn && txFull};

  assign txFreeNext = CW'(DEPTH) - txFillNext;
  assign txReqNext  = 32'(txFreeNext) >= txNeed(txMarkSel, DEPTH);
  assign rxReqNext  = 32'(rxFillNext) >= rxNeed(rxMarkSel, DEPTH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReq    <= 1'b0;
      rxReq    <= 1'b0;
      errFlags <= '0;
    end else begin
      txReq    <= txReqNext;
      rxReq    <= rxReqNext;
      errFlags <= (errFlags & ~errClr) | errSet;
    end
  end

endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair
  import sfp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic [W-1:0]  busWrData,
  input  logic          busRdEn,
  output logic [W-1:0]  busRdData,
  input  logic [2:0]    txMarkSel,
  input  logic [2:0]    rxMarkSel,
  input  logic [3:0]    errClr,
  output logic          txReq,
  output logic          rxReq,
  output logic [CW-1:0] txFreeCnt,
  output logic [CW-1:0] rxFillCnt,
  output logic [3:0]    errFlags,
  input  logic          serTxPop,
  output logic [W-1:0]  serTxData,
  input  logic          serRxPush,
  input  logic [W-1:0]  serRxData
);

  fifoStb_t      txStb, rxStb;
  logic [CW-1:0] txFill, txFillNext, rxFillNext;

  sfp_ctrl #(.DEPTH(DEPTH)) ctrlI (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn),
    .serTxPop(serTxPop), .serRxPush(serRxPush),
    .txMarkSel(txMarkSel), .rxMarkSel(rxMarkSel), .errClr(errClr),
    .txFill(txFill), .txFillNext(txFillNext),
    .rxFill(rxFillCnt), .rxFillNext(rxFillNext),
    .txStb(txStb), .rxStb(rxStb),
    .txReq(txReq), .rxReq(rxReq), .errFlags(errFlags)
  );

  sfp_fifo_dp #(.DEPTH(DEPTH), .W(W)) txDpI (
    .clk(clk), .rstN(rstN), .stb(txStb), .wrData(busWrData),
    .rdData(serTxData), .fill(txFill), .fillNext(txFillNext)
  );

  sfp_fifo_dp #(.DEPTH(DEPTH), .W(W)) rxDpI (
    .clk(clk), .rstN(rstN), .stb(rxStb), .wrData(serRxData),
    .rdData(busRdData), .fill(rxFillCnt), .fillNext(rxFillNext)
  );

  assign txFreeCnt = CW'(DEPTH) - txFill;

endmodule

// File: rtl/sfp_chk.sv
module sfp_chk
  import sfp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          busWrEn,
  input logic          busRdEn,
  input logic          serTxPop,
  input logic          serRxPush,
  input logic [2:0]    txMarkSel,
  input logic [2:0]    rxMarkSel,
  input logic [3:0]    errClr,
  input logic          txReq,
  input logic          rxReq,
  input logic [CW-1:0] txFreeCnt,
  input logic [CW-1:0] rxFillCnt,
  input logic [3:0]    errFlags,
  input logic [W-1:0]  busRdData
);

  // R4
  tx_req_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (txReq == (32'(txFreeCnt) >= txNeed($past(txMarkSel), DEPTH))));

  // R5
  rx_req_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (rxReq == (32'(rxFillCnt) >= rxNeed($past(rxMarkSel), DEPTH))));

  // R8
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !serTxPop && txFreeCnt == '0) |=> (txFreeCnt == '0 && errFlags[0]));

  // R9
  rx_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !serRxPush && rxFillCnt == '0) |=>
      (rxFillCnt == '0 && $stable(busRdData) && errFlags[3]));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags[2] && !errClr[2]) |=> errFlags[2]);

  // R11
  tx_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && serTxPop && txFreeCnt != '0 && txFreeCnt != CW'(DEPTH)) |=> $stable(txFreeCnt));

  // R3
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |-> (rxFillCnt <= CW'(DEPTH)));

endmodule

bind sio_fifo_pair sfp_chk #(.DEPTH(DEPTH), .W(W)) chkI (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .serTxPop(serTxPop), .serRxPush(serRxPush),
  .txMarkSel(txMarkSel), .rxMarkSel(rxMarkSel), .errClr(errClr),
  .txReq(txReq), .rxReq(rxReq), .txFreeCnt(txFreeCnt), .rxFillCnt(rxFillCnt),
  .errFlags(errFlags), .busRdData(busRdData)
);

// File: tb/sio_fifo_pair_tb.sv
module sio_fifo_pair_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busWrEn, busRdEn, serTxPop, serRxPush;
  logic [7:0] busWrData, serRxData, busRdData, serTxData;
  logic [2:0] txMarkSel, rxMarkSel;
  logic [3:0] errClr, errFlags;
  logic       txReq, rxReq;
  logic [4:0] txFreeCnt, rxFillCnt;

  int total = 0;
  int bad   = 0;

  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] expTxData, expRxData;
  logic [3:0] expErr;
  logic       expTxReq, expRxReq;

  always #5 clk = ~clk;

  sio_fifo_pair dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .txMarkSel(txMarkSel),
    .rxMarkSel(rxMarkSel), .errClr(errClr), .txReq(txReq), .rxReq(rxReq),
    .txFreeCnt(txFreeCnt), .rxFillCnt(rxFillCnt), .errFlags(errFlags),
    .serTxPop(serTxPop), .serTxData(serTxData), .serRxPush(serRxPush),
    .serRxData(serRxData)
  );

  function automatic int txLimit(input logic [2:0] s);
    case (s)
      3'b100: return 12; 3'b101: return 8; 3'b110: return 4; 3'b111: return 1;
      default: return 16;
    endcase
  endfunction

  function automatic int rxLimit(input logic [2:0] s);
    case (s)
      3'b100: return 4; 3'b101: return 8; 3'b110: return 12; 3'b111: return 16;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic tp,
                      input logic rp, input logic [7:0] rd, input logic rdEn,
                      input logic [3:0] clr, input logic [2:0] ts, input logic [2:0] rs);
    int  txSz, rxSz;
    logic bothTx, bothRx, prevTx, prevRx;
    logic [3:0] setv;
    busWrEn = wr; busWrData = wd; serTxPop = tp; serRxPush = rp;
    serRxData = rd; busRdEn = rdEn; errClr = clr; txMarkSel = ts; rxMarkSel = rs;
    txSz = txQ.size(); rxSz = rxQ.size();
    bothTx = wr && tp && txSz > 0 && txSz < 16;
    bothRx = rp && rdEn && rxSz > 0 && rxSz < 16;
    setv = {rdEn && rxSz == 0, rp && rxSz == 16, tp && txSz == 0, wr && txSz == 16};
    if (tp && txSz > 0) expTxData = txQ.pop_front();
    if (wr && txSz < 16) txQ.push_back(wd);
    if (rdEn && rxSz > 0) expRxData = rxQ.pop_front();
    if (rp && rxSz < 16) rxQ.push_back(rd);
    expErr = (expErr & ~clr) | setv;
    prevTx = expTxReq; prevRx = expRxReq;
    expTxReq = (16 - txQ.size()) >= txLimit(ts);
    expRxReq = rxQ.size() >= rxLimit(rs);
    @(posedge clk);
    @(negedge clk);
    chk(bothTx ? "R11 txFreeCnt" : "R2 txFreeCnt", int'(txFreeCnt), 16 - txQ.size());
    chk(bothRx ? "R11 rxFillCnt" : "R3 rxFillCnt", int'(rxFillCnt), rxQ.size());
    chk((prevTx && !expTxReq) ? "R7 txReq" : (ts inside {3'b001, 3'b010, 3'b011}) ? "R6 txReq" : "R4 txReq",
        int'(txReq), int'(expTxReq));
    chk((prevRx && !expRxReq) ? "R7 rxReq" : (rs inside {3'b001, 3'b010, 3'b011}) ? "R6 rxReq" : "R5 rxReq",
        int'(rxReq), int'(expRxReq));
    chk((setv[0] || setv[2]) ? "R8 errFlags" : (setv[1] || setv[3]) ? "R9 errFlags" : "R10 errFlags",
        int'(errFlags), int'(expErr));
    chk("R12 serTxData", int'(serTxData), int'(expTxData));
    chk("R12 busRdData", int'(busRdData), int'(expRxData));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rstN = 1'b0;
    busWrEn = 0; busRdEn = 0; serTxPop = 0; serRxPush = 0;
    busWrData = 0; serRxData = 0; errClr = 0; txMarkSel = 0; rxMarkSel = 0;
    expTxData = 0; expRxData = 0; expErr = 0; expTxReq = 0; expRxReq = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txFreeCnt", int'(txFreeCnt), 16);
    chk("R1 rxFillCnt", int'(rxFillCnt), 0);
    chk("R1 errFlags", int'(errFlags), 0);
    chk("R1 txReq", int'(txReq), 0);
    chk("R1 rxReq", int'(rxReq), 0);
    chk("R1 data", int'({serTxData, busRdData}), 0);
    rstN = 1'b1;

    // directed: fill both FIFOs past full, then drain past empty
    for (int i = 0; i < 18; i++)
      step(1'b1, 8'(i + 8'h30), 1'b0, 1'b1, 8'(i + 8'h90), 1'b0, 4'h0, 3'b110, 3'b111);
    step(1'b1, 8'hee, 1'b1, 1'b1, 8'hdd, 1'b1, 4'h0, 3'b111, 3'b110);
    for (int i = 0; i < 18; i++)
      step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 4'h0, 3'b000, 3'b000);
    step(1'b1, 8'h55, 1'b1, 1'b1, 8'h66, 1'b1, 4'hf, 3'b010, 3'b011);
    step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'hf, 3'b101, 3'b101);

    // random phases with varying pressure on each side
    for (int ph = 0; ph < 24; ph++) begin
      int pw = $urandom % 100;
      int pt = $urandom % 100;
      int pr = $urandom % 100;
      int pd = $urandom % 100;
      for (int c = 0; c < 150; c++) begin
        step(($urandom % 100) < pw, 8'($urandom), ($urandom % 100) < pt,
             ($urandom % 100) < pr, 8'($urandom), ($urandom % 100) < pd,
             (($urandom % 8) == 0) ? 4'($urandom) : 4'h0,
             3'($urandom), 3'($urandom));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule